// File: doc/BRIEF.md
# Block Protection Lock Controller

This block keeps the program/erase protection state of a 135-block flash array that is split into two banks. Blocks 0 to 38 form the first bank: eight small parameter blocks, then 31 main blocks. Blocks 39 to 134 form the second bank, which holds 96 main blocks. Protection works in three layers.

- A volatile protect bit per block decides whether the block may be programmed or erased.
- A lock bit per block freezes that protect bit while the write-protect pin is held low.
- A small one-time lock register can permanently close the user half of a 128-bit identification register and permanently shield the security block (block 0).

Commands arrive one per clock as an opcode and a block index. A program/erase request gives a block index and receives a combinational allow decision. The block also tracks which bank an accepted operation occupies, and it refuses requests aimed at the other bank until that operation completes. A query port reads back the protect and lock state of any block. Two resets are kept apart. The ordinary reset restores the volatile state. The power-on reset is the only thing that clears the one-time bits.

Top module: `blkprot_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, every block reads protected (`qry_prot`=1) and unlocked (`qry_lock`=0), and `busy` is 0.
- R2: A command with `cmd_op`=1 (protect) or `cmd_op`=2 (unprotect) sets or clears the protect bit of block `cmd_blk` only. The result is visible one clock after the command is captured, and no other block changes.
- R3: A command with `cmd_op`=3 (lock) sets the lock bit of `cmd_blk`. While that bit is set and `wp_n` is low, protect and unprotect commands to the block are ignored. With `wp_n` high they take effect as usual.
- R4: Lock bits return to 0 only through `rst_n`. A pulse on `rst_n` alone leaves `lockreg` unchanged. Only `por_n` low clears the one-time bits.
- R5: `lockreg[0]` always reads 1, which marks the factory half as never writable. A command with `cmd_op`=4 ORs `cmd_lrdata[0]` into `lockreg[1]` and `cmd_lrdata[1]` into `lockreg[2]`. A one-time bit never returns to 0 while `por_n` is high.
- R6: `otp_allow` is 1 only when `otp_req`=1, `otp_seg`=1 (user half) and `lockreg[1]`=0. A request for the factory half (`otp_seg`=0) is never allowed.
- R7: With no bank conflict, `req_allow` equals `req_valid` AND NOT protect bit of `req_blk` AND NOT (`req_blk`=0 AND `lockreg[2]`=1).
- R8: A request that is allowed when a clock edge samples it starts an operation: from the next clock `busy`=1, and `busy_bank` is 0 for blocks 0 to 38 or 1 for blocks 39 to 134. While busy, requests to the other bank are refused and requests to the same bank follow R7. A pulse on `op_done` clears `busy`.
- R9: Block indices 135 and above are rejected. Commands to them change no block, requests to them are never allowed, and queries on them report protected=1 and locked=0.
- R10: `qry_prot` and `qry_lock` show the current protect and lock bits of block `qry_blk` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the volatile state |
| por_n | input | 1 | Synchronous active-low power-on reset; the only clear of the one-time bits |
| wp_n | input | 1 | Write-protect pin; low freezes locked blocks |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 none, 1 protect, 2 unprotect, 3 lock, 4 program lock register |
| cmd_blk | input | 8 | Target block of the command |
| cmd_lrdata | input | 2 | Bits to set in lockreg[2:1] |
| req_valid | input | 1 | Program/erase request strobe |
| req_blk | input | 8 | Block of the request |
| op_done | input | 1 | The running operation has finished |
| req_allow | output | 1 | The request may proceed |
| otp_req | input | 1 | Request to program the identification register |
| otp_seg | input | 1 | 0 factory half, 1 user half |
| otp_allow | output | 1 | The identification register write may proceed |
| qry_blk | input | 8 | Block to read back |
| qry_prot | output | 1 | Protect bit of qry_blk |
| qry_lock | output | 1 | Lock bit of qry_blk |
| lockreg | output | 3 | One-time lock register |
| busy | output | 1 | An operation occupies a bank |
| busy_bank | output | 1 | Bank of the running operation |

## Verification
The bench sweeps all 135 blocks after reset and after each batch of commands. It compares the query and allow outputs with a model it keeps itself. That sweep would catch an index decoder that aliases out-of-range indices onto real blocks, and it would catch a command that spills onto a neighbouring block. Locked blocks are hit with commands while `wp_n` is both low and high. A design that ignored the pin would either never freeze the block or freeze it for good. A pulse on `rst_n` alone must leave the one-time bits set and block 0 refused. A design that cleared them there would let block 0 be erased again. The bank test puts requests on both sides of the 38/39 boundary while an operation runs. An off-by-one in the bank split would refuse block 38 or admit block 39.

// File: rtl/blkprot_pkg.sv
// Shared opcode type and lock register bit positions for the block
// protection controller. Assumes 3-bit opcodes and a 3-bit lock register.
package blkprot_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROT   = 3'd1,
        OP_UNPROT = 3'd2,
        OP_LOCK   = 3'd3,
        OP_LRPROG = 3'd4
    } blk_op_e;

    localparam int LR_W       = 3;
    localparam int LR_FACTORY = 0;
    localparam int LR_USER    = 1;
    localparam int LR_BLK0    = 2;
endpackage

// File: rtl/blkprot_bits.sv
// Per-block protect and lock bit storage. One slice is generated per block.
// Assumes at most one command per clock. An out-of-range index matches no
// slice, so it is dropped without any further logic.
module blkprot_bits
    import blkprot_pkg::*;
#(
    parameter int NUM_BLOCKS = 135,
    parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wp_n,
    input  logic                  cmd_valid,
    input  blk_op_e               cmd_op,
    input  logic [IDX_W-1:0]      cmd_blk,
    output logic [NUM_BLOCKS-1:0] prot_vec,
    output logic [NUM_BLOCKS-1:0] lock_vec
);
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        logic hit;
        logic frozen;

        // Decode whether this slice is the command target.
        assign hit    = cmd_valid && (cmd_blk == IDX_W'(g));
        // A locked slice ignores protect changes while the pin is low.
        assign frozen = lock_vec[g] && !wp_n;

        // Update the protect bit on protect/unprotect commands.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prot_vec[g] <= 1'b1;
            end else if (hit && !frozen) begin
                if (cmd_op == OP_PROT) begin
                    prot_vec[g] <= 1'b1;
                end else if (cmd_op == OP_UNPROT) begin
                    prot_vec[g] <= 1'b0;
                end
            end
        end

        // Set the lock bit on a lock command; only reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_vec[g] <= 1'b0;
            end else if (hit && cmd_op == OP_LOCK) begin
                lock_vec[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/blkprot_lockreg.sv
// One-time lock register. Bit 0 is a constant 1 that marks the factory half
// as never writable. Bits 1 and 2 can only be set, and only the power-on
// reset clears them. Assumes por_n is low once before use.
module blkprot_lockreg
    import blkprot_pkg::*;
(
    input  logic            clk,
    input  logic            por_n,
    input  logic            wr,
    input  logic [1:0]      wr_bits,
    output logic [LR_W-1:0] lockreg
);
    logic [1:0] otp_q;

    // OR new bits into the stored pair so that a bit can never be cleared.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            otp_q <= 2'b00;
        end else if (wr) begin
            otp_q <= otp_q | wr_bits;
        end
    end

    // Present the register with the fixed factory bit at position 0.
    assign lockreg = {otp_q, 1'b1};
endmodule

// File: rtl/blkprot_bank_arb.sv
// Tracks which bank a running program/erase occupies and flags requests
// that target the other bank. Blocks below BANK_A_BLOCKS are bank 0.
// Assumes the owner raises op_done once per accepted operation.
module blkprot_bank_arb #(
    parameter int BANK_A_BLOCKS = 39,
    parameter int IDX_W         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] req_blk,
    input  logic             op_done,
    output logic             req_bank,
    output logic             conflict,
    output logic             busy,
    output logic             busy_bank
);
    localparam logic [IDX_W-1:0] SPLIT = IDX_W'(BANK_A_BLOCKS);

    // Map the requested block to its bank.
    assign req_bank = (req_blk >= SPLIT);
    // A request conflicts when the other bank is occupied.
    assign conflict = busy && (req_bank != busy_bank);

    // Claim a bank on start and release it on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            busy_bank <= 1'b0;
        end else if (start) begin
            busy      <= 1'b1;
            busy_bank <= req_bank;
        end else if (op_done) begin
            busy      <= 1'b0;
        end
    end
endmodule

// File: rtl/blkprot_ctrl.sv
// Top of the block protection controller. It combines the per-block bits,
// the one-time lock register and the bank tracker into the allow decisions.
// Assumes a single clock and synchronous resets. All decisions are
// combinational from the registered state and the request inputs.
module blkprot_ctrl
    import blkprot_pkg::*;
#(
    parameter int NUM_BLOCKS    = 135,
    parameter int BANK_A_BLOCKS = 39,
    parameter int IDX_W         = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             wp_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_blk,
    input  logic [1:0]       cmd_lrdata,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_blk,
    input  logic             op_done,
    output logic             req_allow,
    input  logic             otp_req,
    input  logic             otp_seg,
    output logic             otp_allow,
    input  logic [IDX_W-1:0] qry_blk,
    output logic             qry_prot,
    output logic             qry_lock,
    output logic [2:0]       lockreg,
    output logic             busy,
    output logic             busy_bank
);
    blk_op_e               op;
    logic [NUM_BLOCKS-1:0] prot_vec;
    logic [NUM_BLOCKS-1:0] lock_vec;
    logic [LR_W-1:0]       lr_q;
    logic                  req_prot;
    logic                  req_bank;
    logic                  conflict;
    logic                  blk0_sealed;

    // Interpret the raw opcode bits.
    assign op = blk_op_e'(cmd_op);

    blkprot_bits #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .IDX_W     (IDX_W)
    ) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .wp_n     (wp_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (op),
        .cmd_blk  (cmd_blk),
        .prot_vec (prot_vec),
        .lock_vec (lock_vec)
    );

    blkprot_lockreg u_lr (
        .clk    (clk),
        .por_n  (por_n),
        .wr     (cmd_valid && op == OP_LRPROG),
        .wr_bits(cmd_lrdata),
        .lockreg(lr_q)
    );

    blkprot_bank_arb #(
        .BANK_A_BLOCKS(BANK_A_BLOCKS),
        .IDX_W        (IDX_W)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_allow),
        .req_blk  (req_blk),
        .op_done  (op_done),
        .req_bank (req_bank),
        .conflict (conflict),
        .busy     (busy),
        .busy_bank(busy_bank)
    );

    // Look up the protect bit of the request target; out of range reads protected.
    always_comb begin
        req_prot = 1'b1;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (req_blk == IDX_W'(i)) req_prot = prot_vec[i];
        end
    end

    // Look up the query target; out of range reads protected and unlocked.
    always_comb begin
        qry_prot = 1'b1;
        qry_lock = 1'b0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (qry_blk == IDX_W'(i)) begin
                qry_prot = prot_vec[i];
                qry_lock = lock_vec[i];
            end
        end
    end

    // The security block is sealed once its one-time bit is set.
    assign blk0_sealed = lr_q[LR_BLK0] && (req_blk == '0);

    // Program/erase decision from the protect bit, the seal and the bank.
    assign req_allow = req_valid && !req_prot && !blk0_sealed && !conflict;

    // Identification register write decision: the user half only, while open.
    assign otp_allow = otp_req && otp_seg && !lr_q[LR_USER];

    assign lockreg = lr_q;

    // req_bank is consumed inside the arbiter; keep the top-level copy tied off.
    logic unused_ok;
    assign unused_ok = req_bank;
endmodule

// File: rtl/blkprot_chk.sv
// Assertion checker for blkprot_ctrl, attached with bind. It observes the
// ports and the internal bit vectors, and recomputes the bank split and the
// index range independently.
module blkprot_chk #(
    parameter int NUM_BLOCKS    = 135,
    parameter int BANK_A_BLOCKS = 39,
    parameter int IDX_W         = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  por_n,
    input logic                  wp_n,
    input logic                  cmd_valid,
    input logic [2:0]            cmd_op,
    input logic [IDX_W-1:0]      cmd_blk,
    input logic                  req_valid,
    input logic [IDX_W-1:0]      req_blk,
    input logic                  req_allow,
    input logic                  otp_seg,
    input logic                  otp_allow,
    input logic [2:0]            lockreg,
    input logic                  busy,
    input logic                  busy_bank,
    input logic [NUM_BLOCKS-1:0] prot_vec,
    input logic [NUM_BLOCKS-1:0] lock_vec
);
    logic tgt_locked;

    // Lock bit of the command target, zero when out of range.
    always_comb begin
        tgt_locked = 1'b0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (cmd_blk == IDX_W'(i)) tgt_locked = lock_vec[i];
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (&prot_vec) && (lock_vec == '0) && !busy);

    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wp_n && tgt_locked && (cmd_op == 3'd1 || cmd_op == 3'd2))
        |=> prot_vec == $past(prot_vec));

    p_lr_oneway_r5: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) |-> ((lockreg & $past(lockreg)) == $past(lockreg)));

    p_factory_bit_r5: assert property (@(posedge clk) disable iff (!por_n)
        lockreg[0]);

    p_otp_rule_r6: assert property (@(posedge clk) disable iff (!por_n)
        otp_allow |-> otp_seg && !lockreg[1]);

    p_blk0_seal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_allow && req_blk == '0) |-> !lockreg[2]);

    p_bank_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && ((req_blk >= IDX_W'(BANK_A_BLOCKS)) != busy_bank))
        |-> !req_allow);

    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_blk >= IDX_W'(NUM_BLOCKS)) |-> !req_allow);
endmodule

bind blkprot_ctrl blkprot_chk #(
    .NUM_BLOCKS   (NUM_BLOCKS),
    .BANK_A_BLOCKS(BANK_A_BLOCKS),
    .IDX_W        (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_n    (por_n),
    .wp_n     (wp_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_blk  (cmd_blk),
    .req_valid(req_valid),
    .req_blk  (req_blk),
    .req_allow(req_allow),
    .otp_seg  (otp_seg),
    .otp_allow(otp_allow),
    .lockreg  (lockreg),
    .busy     (busy),
    .busy_bank(busy_bank),
    .prot_vec (prot_vec),
    .lock_vec (lock_vec)
);

// File: tb/sim_blkprot_ctrl.sv
`timescale 1ns/1ps
module sim_blkprot_ctrl;
    localparam int NB = 135;
    localparam int BA = 39;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, por_n = 1'b0, wp_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_blk = 8'd0;
    logic [1:0] cmd_lrdata = 2'b00;
    logic       req_valid = 1'b0;
    logic [7:0] req_blk = 8'd0;
    logic       op_done = 1'b0;
    logic       otp_req = 1'b0, otp_seg = 1'b0;
    logic [7:0] qry_blk = 8'd0;
    logic       req_allow, otp_allow, qry_prot, qry_lock, busy, busy_bank;
    logic [2:0] lockreg;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;
    bit  exp_prot [NB];
    bit  exp_lock [NB];
    logic [2:0] exp_lr;

    always #2 clk = ~clk;

    blkprot_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
        .cmd_lrdata(cmd_lrdata), .req_valid(req_valid), .req_blk(req_blk),
        .op_done(op_done), .req_allow(req_allow), .otp_req(otp_req),
        .otp_seg(otp_seg), .otp_allow(otp_allow), .qry_blk(qry_blk),
        .qry_prot(qry_prot), .qry_lock(qry_lock), .lockreg(lockreg),
        .busy(busy), .busy_bank(busy_bank)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit power);
        @(negedge clk);
        rst_n = 1'b0;
        if (power) por_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        por_n = 1'b1;
        for (int i = 0; i < NB; i++) begin
            exp_prot[i] = 1'b1;
            exp_lock[i] = 1'b0;
        end
        if (power) exp_lr = 3'b001;
    endtask

    // Issue one command and update the bench model from the requirements.
    task automatic do_cmd(input int op, input int blk, input logic [1:0] lrd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_blk = 8'(blk); cmd_lrdata = lrd;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op == 4) exp_lr = exp_lr | {lrd, 1'b0};
        if (blk < NB) begin
            if (op == 3) exp_lock[blk] = 1'b1;
            if ((op == 1 || op == 2) && !(exp_lock[blk] && !wp_n))
                exp_prot[blk] = (op == 1);
        end
    endtask

    // Present a request for one low phase only, so that no operation starts.
    task automatic probe_req(input int blk, input bit exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_blk = 8'(blk);
        #1;
        chk(tag, req_allow, exp);
        req_valid = 1'b0;
    endtask

    // Compare query and allow outputs with the model for every block.
    task automatic sweep(input string tag);
        for (int i = 0; i < NB; i++) begin
            qry_blk = 8'(i);
            #0.1;
            chk({tag, " R10 prot"}, qry_prot, exp_prot[i]);
            chk({tag, " R10 lock"}, qry_lock, exp_lock[i]);
            probe_req(i, !exp_prot[i] && !(i == 0 && exp_lr[2]), {tag, " R7 allow"});
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: state after a power-on reset.
        do_reset(1'b1);
        #1;
        chk("R1 busy", busy, 0);
        chk("R5 lockreg after power-on", lockreg, 3'b001);
        sweep("R1 reset");

        // R2: unprotect the even blocks, then protect block 4 again.
        for (int i = 0; i < NB; i += 2) do_cmd(2, i, 2'b00);
        do_cmd(1, 4, 2'b00);
        sweep("R2 even");

        // R3: lock blocks 10 and 11, then hit them with the pin low and high.
        do_cmd(3, 10, 2'b00);
        do_cmd(3, 11, 2'b00);
        wp_n = 1'b0;
        do_cmd(1, 10, 2'b00);
        do_cmd(2, 11, 2'b00);
        do_cmd(1, 12, 2'b00);
        qry_blk = 8'd10; #0.1; chk("R3 frozen 10", qry_prot, 0);
        qry_blk = 8'd11; #0.1; chk("R3 frozen 11", qry_prot, 1);
        qry_blk = 8'd12; #0.1; chk("R3 unlocked 12", qry_prot, 1);
        wp_n = 1'b1;
        do_cmd(2, 11, 2'b00);
        qry_blk = 8'd11; #0.1; chk("R3 released 11", qry_prot, 0);
        sweep("R3 locks");

        // R6 and R5: seal the user half, then block 0.
        otp_req = 1'b1;
        otp_seg = 1'b0; #0.1; chk("R6 factory half", otp_allow, 0);
        otp_seg = 1'b1; #0.1; chk("R6 user half open", otp_allow, 1);
        do_cmd(4, 0, 2'b01);
        #0.1;
        chk("R6 user half sealed", otp_allow, 0);
        chk("R5 lockreg bit1", lockreg, exp_lr);
        do_cmd(4, 0, 2'b00);
        chk("R5 no clear", lockreg, exp_lr);
        probe_req(0, 1'b1, "R7 block0 before seal");
        do_cmd(4, 0, 2'b10);
        chk("R5 lockreg bit2", lockreg, 3'b111);
        probe_req(0, 1'b0, "R7 block0 sealed");

        // R4: an ordinary reset keeps the one-time bits.
        do_reset(1'b0);
        #0.1;
        chk("R4 lockreg kept", lockreg, 3'b111);
        otp_seg = 1'b1; #0.1; chk("R4 user half still sealed", otp_allow, 0);
        do_cmd(2, 0, 2'b00);
        sweep("R4 after reset");

        // R8: bank occupancy around the 38/39 split.
        do_cmd(2, 5, 2'b00);
        do_cmd(2, 38, 2'b00);
        do_cmd(2, 39, 2'b00);
        do_cmd(2, 50, 2'b00);
        @(negedge clk);
        req_valid = 1'b1; req_blk = 8'd5;
        #1; chk("R8 start allowed", req_allow, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 busy", busy, 1);
        chk("R8 bank", busy_bank, 0);
        probe_req(50, 1'b0, "R8 other bank 50");
        probe_req(39, 1'b0, "R8 other bank 39");
        probe_req(38, 1'b1, "R8 same bank 38");
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        chk("R8 released", busy, 0);
        probe_req(50, 1'b1, "R8 after done 50");
        @(negedge clk);
        req_valid = 1'b1; req_blk = 8'd39;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 bank B", busy_bank, 1);
        probe_req(38, 1'b0, "R8 other bank 38");
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;

        // R9: out-of-range indices.
        do_cmd(2, 135, 2'b00);
        do_cmd(2, 200, 2'b00);
        do_cmd(3, 255, 2'b00);
        qry_blk = 8'd135; #0.1;
        chk("R9 query prot", qry_prot, 1);
        chk("R9 query lock", qry_lock, 0);
        probe_req(135, 1'b0, "R9 req 135");
        probe_req(255, 1'b0, "R9 req 255");
        sweep("R9 no alias");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule